// File: doc/BRIEF.md
# Region-Decoding Address Translator with Software-Loaded TLB

This block is the front end of address translation for a 32-bit processor. Each request carries a virtual address, a read/write flag and the privilege mode. The block decodes the top three address bits into one of four fixed regions. Two kernel windows are translated directly, without any table. The user window and the upper kernel window go through a small fully associative translation buffer. Its tags are virtual page numbers and its data are page frame numbers with valid and writable flags.

A lookup that finds no usable entry reports a miss fault, so that a software handler can install the mapping through the entry write port. The block never walks page tables itself. A flush input invalidates every entry at once, for use on a context switch. Every result is registered and appears one cycle after the request, together with a cacheable flag for the memory system.

Top module: `xlt_front`

## Requirements
- R1: After synchronous reset `rsp_valid` is 0 and every buffer entry is invalid, so the first mapped lookup misses.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low otherwise.
- R3: A user-region address (bit 31 = 0) that hits gives `rsp_paddr = {pfn, vaddr[11:0]}` (4 KB pages), `rsp_cacheable = 1` and `rsp_cause = 0`.
- R4: In kernel mode, an address from 0x80000000 to 0x9FFFFFFF gives `rsp_paddr = vaddr & 0x1FFFFFFF` with `rsp_cacheable = 1` and no fault, whatever the buffer holds.
- R5: In kernel mode, an address from 0xA0000000 to 0xBFFFFFFF is translated as in R4 but with `rsp_cacheable = 0`.
- R6: A kernel-mode address from 0xC0000000 upward is translated through the buffer exactly as in R3.
- R7: A mapped access with no valid matching entry gives `rsp_fault = 1` with `rsp_cause = 1` (miss). Any fault drives `rsp_paddr = 0` and `rsp_cacheable = 0`.
- R8: In user mode (`req_user = 1`), an address with bit 31 set gives `rsp_cause = 2` (address error). This takes priority over every buffer result.
- R9: A write that hits an entry stored with writable = 0 gives `rsp_cause = 3` (protection). A read of the same entry translates normally.
- R10: A software write replaces the entry at `wr_index` at the clock edge. Later lookups see the new tag and the old tag no longer matches.
- R11: An entry written with `wr_valid = 0` never hits.
- R12: `flush` invalidates every entry at the edge. A software write in the same cycle is discarded. Direct regions are unaffected.
- R13: When several valid entries hold the same tag, the one with the lowest index supplies the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = store access, 0 = load or fetch |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| wr_en | input | 1 | Load a buffer entry |
| wr_index | input | 3 | Entry slot to load |
| wr_vpn | input | 20 | Virtual page number tag |
| wr_pfn | input | 20 | Page frame number |
| wr_valid | input | 1 | Valid flag of the loaded entry |
| wr_writable | input | 1 | Write permission of the loaded entry |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Result present |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_cacheable | output | 1 | 1 = access may be cached |
| rsp_fault | output | 1 | Exception raised |
| rsp_cause | output | 2 | 0 none, 1 miss, 2 address error, 3 protection |

## Verification
Two situations are hard to reach from the ports: several valid entries sharing one tag, and a flush that lands in the same cycle as a software load. Both occur only when software misbehaves or events collide. The bench creates them on purpose. It first loads a second copy of a tag into a higher slot and checks which frame comes back. It then raises flush and a write together and checks that a lookup of the written page still misses, while a direct-region access right after the flush translates unchanged.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  typedef enum logic [1:0] {
    RG_USER    = 2'd0,
    RG_KDIR_C  = 2'd1,
    RG_KDIR_U  = 2'd2,
    RG_KMAPPED = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_MISS = 2'd1,
    CAUSE_ADDR = 2'd2,
    CAUSE_PROT = 2'd3
  } cause_e;
endpackage

// File: rtl/xlt_region_dec.sv
module xlt_region_dec
  import xlt_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic [VA_W-1:0] vaddr,
  output region_e         region
);
  logic [2:0] top3;
  assign top3 = vaddr[VA_W-1 -: 3];

  always_comb begin
    unique casez (top3)
      3'b0??:  region = RG_USER;
      3'b100:  region = RG_KDIR_C;
      3'b101:  region = RG_KDIR_U;
      default: region = RG_KMAPPED;
    endcase
  end
endmodule

// File: rtl/xlt_tlb_cam.sv
module xlt_tlb_cam #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic [VPN_W-1:0]           wr_vpn,
  input  logic [PFN_W-1:0]           wr_pfn,
  input  logic                       wr_valid,
  input  logic                       wr_writable,
  input  logic [VPN_W-1:0]           lk_vpn,
  output logic                       lk_hit,
  output logic [PFN_W-1:0]           lk_pfn,
  output logic                       lk_writable
);
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] wen_q;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [ENTRIES-1:0] match;

  // Valid bits carry reset and flush; payload needs neither.
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tag_q[wr_idx] <= wr_vpn;
      pfn_q[wr_idx] <= wr_pfn;
      wen_q[wr_idx] <= wr_writable;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (tag_q[g] == lk_vpn);
  end

  // Descending scan so the lowest matching index is the last to assign.
  always_comb begin
    lk_hit      = |match;
    lk_pfn      = '0;
    lk_writable = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        lk_pfn      = pfn_q[i];
        lk_writable = wen_q[i];
      end
    end
  end
endmodule

// File: rtl/xlt_front.sv
module xlt_front
  import xlt_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PAGE_W  = 12,
  parameter int PFN_W   = 20,
  parameter int ENTRIES = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic [VA_W-1:0]            req_vaddr,
  input  logic                       req_write,
  input  logic                       req_user,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_index,
  input  logic [VA_W-PAGE_W-1:0]     wr_vpn,
  input  logic [PFN_W-1:0]           wr_pfn,
  input  logic                       wr_valid,
  input  logic                       wr_writable,
  input  logic                       flush,
  output logic                       rsp_valid,
  output logic [PFN_W+PAGE_W-1:0]    rsp_paddr,
  output logic                       rsp_cacheable,
  output logic                       rsp_fault,
  output logic [1:0]                 rsp_cause
);
  localparam int VPN_W  = VA_W - PAGE_W;
  localparam int PA_W   = PFN_W + PAGE_W;
  localparam int DIR_W  = VA_W - 3;

  region_e          region;
  logic             hit, hit_wr;
  logic [PFN_W-1:0] hit_pfn;
  cause_e           n_cause;
  logic [PA_W-1:0]  n_pa;
  logic             n_cache;

  xlt_region_dec #(.VA_W(VA_W)) u_dec (
    .vaddr  (req_vaddr),
    .region (region)
  );

  xlt_tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_cam (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .wr_en       (wr_en),
    .wr_idx      (wr_index),
    .wr_vpn      (wr_vpn),
    .wr_pfn      (wr_pfn),
    .wr_valid    (wr_valid),
    .wr_writable (wr_writable),
    .lk_vpn      (req_vaddr[VA_W-1:PAGE_W]),
    .lk_hit      (hit),
    .lk_pfn      (hit_pfn),
    .lk_writable (hit_wr)
  );

  always_comb begin
    n_cause = CAUSE_NONE;
    n_pa    = '0;
    n_cache = 1'b0;
    if (req_user && region != RG_USER) begin
      n_cause = CAUSE_ADDR;
    end else if (region == RG_KDIR_C || region == RG_KDIR_U) begin
      n_pa    = PA_W'(req_vaddr[DIR_W-1:0]);
      n_cache = (region == RG_KDIR_C);
    end else if (!hit) begin
      n_cause = CAUSE_MISS;
    end else if (req_write && !hit_wr) begin
      n_cause = CAUSE_PROT;
    end else begin
      n_pa    = {hit_pfn, req_vaddr[PAGE_W-1:0]};
      n_cache = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_paddr     <= '0;
      rsp_cacheable <= 1'b0;
      rsp_fault     <= 1'b0;
      rsp_cause     <= CAUSE_NONE;
    end else begin
      rsp_valid     <= req_valid;
      rsp_paddr     <= req_valid ? n_pa : '0;
      rsp_cacheable <= req_valid && n_cache;
      rsp_fault     <= req_valid && (n_cause != CAUSE_NONE);
      rsp_cause     <= req_valid ? n_cause : CAUSE_NONE;
    end
  end
endmodule

// File: rtl/xlt_front_chk.sv
module xlt_front_chk #(
  parameter int VA_W    = 32,
  parameter int PAGE_W  = 12,
  parameter int PFN_W   = 20,
  parameter int ENTRIES = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req_valid,
  input logic [VA_W-1:0]         req_vaddr,
  input logic                    req_user,
  input logic                    flush,
  input logic                    rsp_valid,
  input logic [PFN_W+PAGE_W-1:0] rsp_paddr,
  input logic                    rsp_cacheable,
  input logic                    rsp_fault,
  input logic [1:0]              rsp_cause
);
  localparam int PA_W = PFN_W + PAGE_W;

  a_r1_reset_idle: assert property (@(posedge clk) $past(rst) |-> !rsp_valid);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  a_r4_direct_window: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_user && req_vaddr[VA_W-1 -: 2] == 2'b10) |=>
    (!rsp_fault && rsp_paddr == PA_W'($past(req_vaddr[VA_W-4:0]))));

  a_r5_uncached_window: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_user && req_vaddr[VA_W-1 -: 3] == 3'b101) |=> !rsp_cacheable);

  a_r7_fault_quiet: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_paddr == '0 && !rsp_cacheable && rsp_cause != 2'd0));

  a_r8_user_high: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_user && req_vaddr[VA_W-1]) |=> (rsp_fault && rsp_cause == 2'd2));

  a_r12_flush_misses: assert property (@(posedge clk) disable iff (rst)
    ($past(flush) && req_valid && !req_user &&
     (!req_vaddr[VA_W-1] || req_vaddr[VA_W-1 -: 2] == 2'b11)) |=>
    (rsp_fault && rsp_cause == 2'd1));
endmodule

bind xlt_front xlt_front_chk #(
  .VA_W(VA_W), .PAGE_W(PAGE_W), .PFN_W(PFN_W), .ENTRIES(ENTRIES)
) u_chk (.*);

// File: tb/test_xlt_front.sv
module test_xlt_front;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic        usr;
    logic [1:0]  cause;
    logic [31:0] pa;
    logic        cache;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{32'h0040_0123, 1'b0, 1'b0, 2'd0, 32'h1234_5123, 1'b1, 4'd3},  // R3 kernel read
    '{32'h0040_0FFF, 1'b1, 1'b1, 2'd0, 32'h1234_5FFF, 1'b1, 4'd3},  // R3 user write
    '{32'h7FFF_F800, 1'b0, 1'b1, 2'd0, 32'h00AB_C800, 1'b1, 4'd3},  // R3 top user page
    '{32'h7FFF_F800, 1'b1, 1'b1, 2'd3, 32'h0,         1'b0, 4'd9},  // R9 read-only page
    '{32'h8000_1234, 1'b0, 1'b0, 2'd0, 32'h0000_1234, 1'b1, 4'd4},  // R4
    '{32'h9FFF_FFFF, 1'b1, 1'b0, 2'd0, 32'h1FFF_FFFF, 1'b1, 4'd4},  // R4 upper edge
    '{32'hA000_0010, 1'b0, 1'b0, 2'd0, 32'h0000_0010, 1'b0, 4'd5},  // R5
    '{32'hBFFF_FFFC, 1'b1, 1'b0, 2'd0, 32'h1FFF_FFFC, 1'b0, 4'd5},  // R5 upper edge
    '{32'hC000_0ABC, 1'b0, 1'b0, 2'd0, 32'h0F00_FABC, 1'b1, 4'd6},  // R6
    '{32'hFFFF_F004, 1'b1, 1'b0, 2'd3, 32'h0,         1'b0, 4'd9},  // R9 kernel mapped
    '{32'hFFFF_F004, 1'b0, 1'b0, 2'd0, 32'h0000_1004, 1'b1, 4'd6},  // R6 top page
    '{32'h0040_1000, 1'b0, 1'b0, 2'd1, 32'h0,         1'b0, 4'd7},  // R7 miss
    '{32'h8000_1234, 1'b0, 1'b1, 2'd2, 32'h0,         1'b0, 4'd8},  // R8 direct window
    '{32'hC000_0ABC, 1'b0, 1'b1, 2'd2, 32'h0,         1'b0, 4'd8},  // R8 despite hit
    '{32'h0050_0000, 1'b0, 1'b0, 2'd1, 32'h0,         1'b0, 4'd11}, // R11 invalid entry
    '{32'hA000_0000, 1'b1, 1'b1, 2'd2, 32'h0,         1'b0, 4'd8}   // R8 uncached window
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        wr_en = 1'b0, wr_valid = 1'b0, wr_writable = 1'b0, flush = 1'b0;
  logic [2:0]  wr_index = '0;
  logic [19:0] wr_vpn = '0, wr_pfn = '0;
  logic        rsp_valid, rsp_cacheable, rsp_fault;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_cause;

  int applied = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  xlt_front i_xlt_front (
    .clk, .rst, .req_valid, .req_vaddr, .req_write, .req_user,
    .wr_en, .wr_index, .wr_vpn, .wr_pfn, .wr_valid, .wr_writable, .flush,
    .rsp_valid, .rsp_paddr, .rsp_cacheable, .rsp_fault, .rsp_cause
  );

  initial forever #(CLK_PERIOD / 2) clk = ~clk;

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  endtask

  task automatic load(input logic [2:0] idx, input logic [19:0] vpn, input logic [19:0] pfn,
                      input logic v, input logic w, input logic fl);
    @(negedge clk);
    wr_en = 1'b1; wr_index = idx; wr_vpn = vpn; wr_pfn = pfn;
    wr_valid = v; wr_writable = w; flush = fl;
    @(negedge clk);
    wr_en = 1'b0; flush = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic wr, input logic usr,
                      input logic [1:0] ecause, input logic [31:0] epa, input logic ecache,
                      input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
    @(negedge clk);
    req_valid = 1'b0;
    applied++;
    if (rsp_valid !== 1'b1 || rsp_cause !== ecause || rsp_fault !== (ecause != 2'd0) ||
        rsp_paddr !== epa || rsp_cacheable !== ecache) begin
      miscompares++;
      $display("FAIL %s va=%h: got v=%b cause=%0d fault=%b pa=%h c=%b, exp v=1 cause=%0d fault=%b pa=%h c=%b",
               tag, va, rsp_valid, rsp_cause, rsp_fault, rsp_paddr, rsp_cacheable,
               ecause, (ecause != 2'd0), epa, ecache);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got no completion, exp completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: idle after reset
    applied++;
    if (rsp_valid !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 rsp_valid after reset: got %b exp 0", rsp_valid);
    end
    look(32'h0040_0123, 1'b0, 1'b0, 2'd1, 32'h0, 1'b0, "R1 empty buffer");

    // Preload: slot 4 written invalid for R11.
    load(3'd0, 20'h00400, 20'h12345, 1'b1, 1'b1, 1'b0);
    load(3'd1, 20'h7FFFF, 20'h00ABC, 1'b1, 1'b0, 1'b0);
    load(3'd2, 20'hC0000, 20'h0F00F, 1'b1, 1'b1, 1'b0);
    load(3'd3, 20'hFFFFF, 20'h00001, 1'b1, 1'b0, 1'b0);
    load(3'd4, 20'h00500, 20'h55555, 1'b0, 1'b1, 1'b0);

    for (int k = 0; k < NV; k++) begin
      look(VECS[k].va, VECS[k].wr, VECS[k].usr, VECS[k].cause, VECS[k].pa, VECS[k].cache,
           $sformatf("R%0d vec%0d", VECS[k].rq, k));
    end

    // R2: no request, no response
    @(negedge clk);
    applied++;
    if (rsp_valid !== 1'b0) begin
      miscompares++;
      $display("FAIL R2 idle cycle: got rsp_valid=%b exp 0", rsp_valid);
    end

    // R9: read of read-only page in kernel mode translates
    look(32'h7FFF_F000, 1'b0, 1'b0, 2'd0, 32'h00AB_C000, 1'b1, "R9 read allowed");

    // R10: overwrite slot 0
    load(3'd0, 20'h00600, 20'h22222, 1'b1, 1'b1, 1'b0);
    look(32'h0040_0123, 1'b0, 1'b0, 2'd1, 32'h0, 1'b0, "R10 old tag gone");
    look(32'h0060_0010, 1'b0, 1'b0, 2'd0, 32'h2222_2010, 1'b1, "R10 new tag");

    // R13: duplicate tag in slot 6, slot 0 wins
    load(3'd6, 20'h00600, 20'h33333, 1'b1, 1'b1, 1'b0);
    look(32'h0060_0ABC, 1'b1, 1'b0, 2'd0, 32'h2222_2ABC, 1'b1, "R13 lowest index");

    // R12: flush with a colliding write to slot 7
    load(3'd7, 20'h00700, 20'h44444, 1'b1, 1'b1, 1'b1);
    look(32'h0060_0010, 1'b0, 1'b0, 2'd1, 32'h0, 1'b0, "R12 flushed");
    look(32'h0070_0000, 1'b0, 1'b0, 2'd1, 32'h0, 1'b0, "R12 write discarded");
    look(32'hC000_0ABC, 1'b0, 1'b0, 2'd1, 32'h0, 1'b0, "R12 kernel mapped flushed");
    look(32'h8000_0040, 1'b0, 1'b0, 2'd0, 32'h0000_0040, 1'b1, "R12 direct unaffected");

    report();
  end
endmodule